// File: doc/BRIEF.md
# Raster Rectangle Region Detector

This block marks the part of the raster that falls inside a programmed rectangle. Each pixel clock it takes the current pixel column and scan line from the raster counters. It compares them with four bounds: left, right, top and bottom. One clock later it raises a single output bit whenever the beam lies inside the rectangle. The output can be used to clip a crosshair cursor, to sample an analog comparator during a chosen area, or to raise an interrupt at a fixed line of the frame.

Software writes the bounds through a small write port that holds a 2-bit field select and 16 bits of data. The written values go into a pending copy. They, and the detector enable level, move into the working copy only when a vertical-blank-start pulse arrives, so a rectangle never changes halfway through a frame. A force input bypasses the shadowing and drives the output high straight away. Column bounds resolve only to four-pixel steps, while line bounds resolve to a single line. Each axis uses a half-open interval: the low bound is the first position inside and the high bound is the first position outside. The raster counters are generated elsewhere, and so is the translation from display coordinates, where the visible area spans columns 212 to 1235 and lines 34 to 897.

Top module: `region_det`

## Requirements
- R1: After reset, with force low, inside_o is 0, and all working bounds and the working enable are 0.
- R2: Bits [1:0] of both column bounds are ignored and treated as 0. For example, a left bound written as 215 acts as 212 and a right bound written as 1238 acts as 1236. Line bounds use every bit.
- R3: A position is inside when left ≤ pix_x < right and top ≤ line_y < bottom. The low bound is inclusive and the high bound is exclusive.
- R4: A write with wr_sel 0 (left), 1 (right), 2 (top) or 3 (bottom) changes only the pending bound. Detection uses the working bounds, which take the pending values only on the cycle after vblank_start is high.
- R5: det_en is captured into the working enable only at vblank_start. While the working enable is 0 and det_force is 0, inside_o is 0.
- R6: When det_force is 1, inside_o is 1 on the next cycle. This holds whatever the enable, the bounds or the position, and it is not shadowed.
- R7: If the effective high bound on an axis is less than or equal to its low bound, that axis never counts as inside, so inside_o stays 0 unless det_force is 1.
- R8: inside_o is registered. It reflects the inputs present at the previous rising clock edge.
- R9: A write made in the same cycle as vblank_start is not part of that load. It waits in the pending copy for the next vblank_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a bound |
| wr_sel | input | 2 | Bound select: 0 left, 1 right, 2 top, 3 bottom |
| wr_data | input | 16 | Bound value |
| det_en | input | 1 | Detector enable level, captured at vertical blank |
| det_force | input | 1 | Forces the output high, immediate |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| pix_x | input | 16 | Current raster column |
| line_y | input | 16 | Current raster line |
| inside_o | output | 1 | Beam-inside-rectangle flag, registered |

## Verification
Every cycle the assertions check that force wins on the next cycle and that a disabled detector stays quiet. They also check that the working bounds move only on the cycle after a vertical-blank pulse and then equal the pending values, and that an empty column interval or a line outside the working bounds gives a low output. The bench scenarios show the things a single-cycle property cannot. These are the exact edge pixels of the four-pixel column quantisation, the exclusive high bounds, the one-cycle latency seen at the ports, and a write that collides with the vertical-blank pulse and lands one frame late.

// File: rtl/region_det.sv
module region_det #(
  parameter int W = 16,
  parameter int QB = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         det_en,
  input  logic         det_force,
  input  logic         vblank_start,
  input  logic [W-1:0] pix_x,
  input  logic [W-1:0] line_y,
  output logic         inside_o
);
  localparam int NB = 4;

  logic [W-1:0] pend [NB];
  logic [W-1:0] act  [NB];
  logic         en_act;

  for (genvar i = 0; i < NB; i++) begin : g_bound
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pend[i] <= '0;
      else if (wr_en && wr_sel == 2'(i)) pend[i] <= wr_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) act[i] <= '0;
      else if (vblank_start) act[i] <= pend[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_act <= 1'b0;
    else if (vblank_start) en_act <= det_en;

  logic [W-1:0] x_lo, x_hi;
  assign x_lo = {act[0][W-1:QB], {QB{1'b0}}};
  assign x_hi = {act[1][W-1:QB], {QB{1'b0}}};

  logic x_in, y_in;
  assign x_in = (pix_x >= x_lo) && (pix_x < x_hi);
  assign y_in = (line_y >= act[2]) && (line_y < act[3]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inside_o <= 1'b0;
    else inside_o <= det_force || (en_act && x_in && y_in);
endmodule

// File: rtl/region_det_chk.sv
module region_det_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         det_force,
  input logic         vblank_start,
  input logic [W-1:0] line_y,
  input logic         en_act,
  input logic [W-1:0] a_xl, a_xh, a_yt, a_yb,
  input logic [W-1:0] p_xl, p_xh, p_yt, p_yb,
  input logic         inside_o
);
  // R6
  force_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_force |=> inside_o);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_force && !en_act) |=> !inside_o);

  // R7
  empty_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_force && a_xh[W-1:2] <= a_xl[W-1:2]) |=> !inside_o);

  // R3
  y_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_force && (line_y < a_yt || line_y >= a_yb)) |=> !inside_o);

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> ($stable(a_xl) && $stable(a_xh) && $stable(a_yt) && $stable(a_yb)));

  // R4
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> (a_xl == $past(p_xl) && a_xh == $past(p_xh) &&
                      a_yt == $past(p_yt) && a_yb == $past(p_yb)));
endmodule

bind region_det region_det_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_force(det_force), .vblank_start(vblank_start),
  .line_y(line_y), .en_act(en_act),
  .a_xl(act[0]), .a_xh(act[1]), .a_yt(act[2]), .a_yb(act[3]),
  .p_xl(pend[0]), .p_xh(pend[1]), .p_yt(pend[2]), .p_yb(pend[3]),
  .inside_o(inside_o)
);

// File: tb/tb_region_det.sv
module tb_region_det;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic        det_en = 0, det_force = 0, vblank_start = 0;
  logic [15:0] pix_x = 0, line_y = 0;
  logic        inside_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  region_det dut (.*);

  task automatic chk(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: inside_o=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic vbl();
    @(negedge clk); vblank_start = 1;
    @(negedge clk); vblank_start = 0;
  endtask

  task automatic probe(input logic [15:0] x, input logic [15:0] y,
                       input logic exp, input string req);
    @(negedge clk); pix_x = x; line_y = y;
    @(posedge clk); #1;
    chk(inside_o, exp, req);
  endtask

  task automatic t_reset();
    chk(inside_o, 1'b0, "R1 reset");
    probe(16'd0, 16'd0, 1'b0, "R1 empty after reset");
  endtask

  task automatic t_shadow();
    det_en = 1; vbl();
    wr(2'd0, 16'd215); wr(2'd1, 16'd1238); wr(2'd2, 16'd34); wr(2'd3, 16'd898);
    probe(16'd500, 16'd500, 1'b0, "R4 before vblank");
    vbl();
    probe(16'd500, 16'd500, 1'b1, "R4 after vblank");
  endtask

  task automatic t_edges();
    probe(16'd212, 16'd500, 1'b1, "R2 left quantised");
    probe(16'd211, 16'd500, 1'b0, "R2 left minus one");
    probe(16'd1235, 16'd500, 1'b1, "R2 right last");
    probe(16'd1236, 16'd500, 1'b0, "R2 right quantised");
    probe(16'd600, 16'd34, 1'b1, "R3 top inclusive");
    probe(16'd600, 16'd33, 1'b0, "R3 above top");
    probe(16'd600, 16'd897, 1'b1, "R3 bottom last");
    probe(16'd600, 16'd898, 1'b0, "R3 bottom exclusive");
  endtask

  task automatic t_latency();
    probe(16'd0, 16'd500, 1'b0, "R8 outside");
    @(negedge clk); pix_x = 16'd700;
    #1 chk(inside_o, 1'b0, "R8 no combinational path");
    @(posedge clk); #1;
    chk(inside_o, 1'b1, "R8 one-cycle latency");
  endtask

  task automatic t_enable();
    @(negedge clk); det_en = 0;
    probe(16'd700, 16'd500, 1'b1, "R5 enable shadowed");
    vbl();
    probe(16'd700, 16'd500, 1'b0, "R5 disabled");
  endtask

  task automatic t_force();
    @(negedge clk); det_force = 1;
    probe(16'd0, 16'd0, 1'b1, "R6 force while disabled");
    @(negedge clk); det_force = 0;
    @(posedge clk); #1;
    chk(inside_o, 1'b0, "R6 force released");
    @(negedge clk); det_en = 1; vblank_start = 1;
    @(negedge clk); vblank_start = 0;
  endtask

  task automatic t_collide();
    @(negedge clk); wr_en = 1; wr_sel = 2'd0; wr_data = 16'd800; vblank_start = 1;
    @(negedge clk); wr_en = 0; vblank_start = 0;
    probe(16'd700, 16'd500, 1'b1, "R9 write missed load");
    vbl();
    probe(16'd700, 16'd500, 1'b0, "R9 write loaded next vblank");
    probe(16'd800, 16'd500, 1'b1, "R9 new left bound");
  endtask

  task automatic t_empty();
    wr(2'd0, 16'd200); wr(2'd1, 16'd100); vbl();
    probe(16'd150, 16'd500, 1'b0, "R7 inverted x");
    probe(16'd500, 16'd500, 1'b0, "R7 inverted x far");
    wr(2'd0, 16'd100); wr(2'd1, 16'd103); vbl();
    probe(16'd100, 16'd500, 1'b0, "R7 collapses after quantising");
    wr(2'd1, 16'd400); wr(2'd2, 16'd50); wr(2'd3, 16'd50); vbl();
    probe(16'd200, 16'd50, 1'b0, "R7 equal y bounds");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_shadow();
    t_edges();
    t_latency();
    t_enable();
    t_force();
    t_collide();
    t_empty();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule